// File: doc/BRIEF.md
# Boost Switch Pulse Timer

This block times the gate drive of a boost converter's power switch from a single comparator bit that reports whether the converter output sits above its regulation reference. In normal (fixed-frequency) operation every switching cycle is a minimum on-interval followed by a programmed off-interval. The off count is meant to be chosen so that the total period stays close to the intended switching frequency.

At the last cycle of every off-interval the block samples the comparator. If the output is still above the reference, the block enters pulse-frequency mode. In that mode it stops issuing pulses until the comparator reports the output has fallen below the reference. It then fires one on-pulse of a separate, longer length, followed by the normal off-interval. A below-reference reading at the end of an off-interval returns the block to fixed-frequency operation. All lengths are given in system clock cycles. Deasserting the enable stops switching at once and clears all timing state.

Top module: `boost_pulse_timer`

## Requirements
- R1: With `rst` high or `en` low, `sw_drive` and `pfm_mode` read 0 from the next clock edge onward.
- R2: In fixed-frequency mode each switch pulse keeps `sw_drive` at 1 for exactly `on_len_pwm` cycles. After `en` rises, the first pulse starts at the next clock edge.
- R3: Every switch pulse is followed by an off-interval of exactly `off_len` cycles with `sw_drive` at 0.
- R4: If `above_ref` is 1 at the last cycle of an off-interval, `pfm_mode` becomes 1 at the next edge and no pulse starts.
- R5: While `pfm_mode` is 1 and the block is waiting with `above_ref` at 1, `sw_drive` stays 0 for as long as `above_ref` stays 1.
- R6: In pulse-frequency mode, the edge after `above_ref` is seen at 0 starts a pulse that lasts exactly `on_len_pfm` cycles. `pfm_mode` stays 1 during that pulse.
- R7: If `above_ref` is 0 at the last cycle of an off-interval, `pfm_mode` becomes 0 at the next edge and a new `on_len_pwm` pulse starts at that same edge.
- R8: Dropping `en` during a pulse ends it at the next edge. Raising `en` again starts a fresh full-length fixed-frequency pulse.
- R9: `above_ref` has no effect during a pulse or before the last cycle of an off-interval. Pulse and off lengths stay unchanged whatever it does there.
- R10: A length input of 0 is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Converter enable; low forces the switch off and clears state |
| above_ref | input | 1 | Comparator: 1 when the output is above the reference |
| on_len_pwm | input | CNT_W | On-time in clock cycles for fixed-frequency mode |
| on_len_pfm | input | CNT_W | Lengthened on-time in clock cycles for pulse-frequency mode |
| off_len | input | CNT_W | Minimum off-time in clock cycles |
| sw_drive | output | 1 | Registered switch gate drive |
| pfm_mode | output | 1 | Registered flag, 1 in pulse-frequency mode |

## Verification
The assertions assume that `above_ref` is already synchronous to `clk`, and that `rst` is sampled only at the clock edge. They also assume that the three length inputs are changed only while `en` is low, so a length is never reloaded half-way through an interval. The stimulus drives every input on the falling edge, holds the length registers constant for each enabled run, and moves the comparator only between rising edges. The comparator is also toggled during pulses and early in off-intervals, to show that it is ignored there.

// File: rtl/boost_timer_pkg.sv
package boost_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    SEL_PWM = 2'd0,
    SEL_PFM = 2'd1,
    SEL_OFF = 2'd2
  } len_sel_e;

endpackage

// File: rtl/boost_span_counter.sv
module boost_span_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  // A length of N occupies N cycles: load N-1, run down to zero.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= ZERO;
    end else if (load) begin
      cnt_q <= (load_val == ZERO) ? ZERO : load_val - ONE;
    end else if (cnt_q != ZERO) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign expired = (cnt_q == ZERO);

  // Lengths 0 and 1 both end after a single cycle.
  assert_short_len_R10: assert property (@(posedge clk) disable iff (rst)
    (load && !clr && load_val <= ONE) |=> expired);

endmodule

// File: rtl/boost_mode_fsm.sv
module boost_mode_fsm
  import boost_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     above_ref,
  input  logic     span_done,
  output phase_e   phase_q,
  output phase_e   phase_d,
  output logic     pfm_q,
  output logic     load,
  output len_sel_e sel
);

  logic pfm_d;

  always_comb begin
    phase_d = phase_q;
    pfm_d   = pfm_q;
    load    = 1'b0;
    sel     = SEL_PWM;
    if (!en) begin
      phase_d = PH_IDLE;
      pfm_d   = 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_ON;
          pfm_d   = 1'b0;
          load    = 1'b1;
          sel     = SEL_PWM;
        end
        PH_ON: begin
          if (span_done) begin
            phase_d = PH_OFF;
            load    = 1'b1;
            sel     = SEL_OFF;
          end
        end
        PH_OFF: begin
          // Mode decision: only at the last off cycle.
          if (span_done) begin
            if (above_ref) begin
              phase_d = PH_HOLD;
              pfm_d   = 1'b1;
            end else begin
              phase_d = PH_ON;
              pfm_d   = 1'b0;
              load    = 1'b1;
              sel     = SEL_PWM;
            end
          end
        end
        PH_HOLD: begin
          if (!above_ref) begin
            phase_d = PH_ON;
            load    = 1'b1;
            sel     = SEL_PFM;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      pfm_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pfm_q   <= pfm_d;
    end
  end

  // Pulse-frequency mode is entered only out of an off-interval.
  assert_pfm_entry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pfm_q) |-> $past(phase_q) == PH_OFF);

  // The off-interval can only be left through the mode decision.
  assert_off_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (en && phase_q == PH_OFF && !span_done) |=> phase_q == PH_OFF);

endmodule

// File: rtl/boost_pulse_timer.sv
module boost_pulse_timer
  import boost_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             above_ref,
  input  logic [CNT_W-1:0] on_len_pwm,
  input  logic [CNT_W-1:0] on_len_pfm,
  input  logic [CNT_W-1:0] off_len,
  output logic             sw_drive,
  output logic             pfm_mode
);

  phase_e           phase_q;
  phase_e           phase_d;
  logic             pfm_q;
  logic             load;
  len_sel_e         sel;
  logic             span_done;
  logic [CNT_W-1:0] len_mux;

  boost_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .above_ref (above_ref),
    .span_done (span_done),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .pfm_q     (pfm_q),
    .load      (load),
    .sel       (sel)
  );

  always_comb begin
    unique case (sel)
      SEL_PFM: len_mux = on_len_pfm;
      SEL_OFF: len_mux = off_len;
      default: len_mux = on_len_pwm;
    endcase
  end

  boost_span_counter #(.CNT_W(CNT_W)) u_span (
    .clk      (clk),
    .rst      (rst),
    .clr      (!en),
    .load     (load),
    .load_val (len_mux),
    .expired  (span_done)
  );

  // Registered gate drive, aligned with the phase register.
  always_ff @(posedge clk) begin
    if (rst) begin
      sw_drive <= 1'b0;
    end else begin
      sw_drive <= (phase_d == PH_ON);
    end
  end

  assign pfm_mode = pfm_q;

  assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!sw_drive && !pfm_mode));

  assert_enter_pfm_R4: assert property (@(posedge clk) disable iff (rst)
    (en && phase_q == PH_OFF && span_done && above_ref) |=> (pfm_mode && !sw_drive));

  assert_hold_low_R5: assert property (@(posedge clk) disable iff (rst)
    (en && pfm_mode && !sw_drive && above_ref) |=> !sw_drive);

  assert_pfm_fire_R6: assert property (@(posedge clk) disable iff (rst)
    (en && phase_q == PH_HOLD && !above_ref) |=> (sw_drive && pfm_mode));

  assert_back_to_pwm_R7: assert property (@(posedge clk) disable iff (rst)
    (en && phase_q == PH_OFF && span_done && !above_ref) |=> (sw_drive && !pfm_mode));

endmodule

// File: tb/tb_boost_pulse_timer.sv
module tb_boost_pulse_timer;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int NVEC       = 6;
  localparam int LIMIT      = 400;

  // {on_len_pwm, off_len, expected high, expected low}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd4,  8'd6,  8'd4,  8'd6},
    {8'd1,  8'd1,  8'd1,  8'd1},
    {8'd0,  8'd3,  8'd1,  8'd3},
    {8'd7,  8'd0,  8'd7,  8'd1},
    {8'd10, 8'd20, 8'd10, 8'd20},
    {8'd3,  8'd2,  8'd3,  8'd2}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en = 1'b0;
  logic             above_ref = 1'b0;
  logic [CNT_W-1:0] on_len_pwm = '0;
  logic [CNT_W-1:0] on_len_pfm = '0;
  logic [CNT_W-1:0] off_len = '0;
  logic             sw_drive;
  logic             pfm_mode;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boost_pulse_timer #(.CNT_W(CNT_W)) dut (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .above_ref  (above_ref),
    .on_len_pwm (on_len_pwm),
    .on_len_pfm (on_len_pfm),
    .off_len    (off_len),
    .sw_drive   (sw_drive),
    .pfm_mode   (pfm_mode)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (sw_drive == lvl && n < LIMIT) begin
      n++;
      step();
    end
  endtask

  task automatic wait_rise();
    for (int i = 0; i < LIMIT; i++) begin
      if (sw_drive) return;
      step();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int hi;
    int lo;
    // R1: reset holds outputs low even with enable high
    step();
    en = 1'b1;
    step(); step();
    check("R1 reset sw", int'(sw_drive), 0);
    check("R1 reset pfm", int'(pfm_mode), 0);
    en = 1'b0;
    rst = 1'b0;
    step(); step();
    check("R1 disabled sw", int'(sw_drive), 0);

    // R2 R3 R10: fixed-frequency lengths from the table
    for (int v = 0; v < NVEC; v++) begin
      en = 1'b0;
      step();
      on_len_pwm = VEC[v][31:24];
      off_len    = VEC[v][23:16];
      on_len_pfm = 8'd9;
      en = 1'b1;
      step();
      check("R2 first pulse starts", int'(sw_drive), 1);
      count_level(1'b1, hi);
      count_level(1'b0, lo);
      check("R2 R10 on length", hi, int'(VEC[v][15:8]));
      check("R3 R10 off length", lo, int'(VEC[v][7:0]));
      check("R7 stays pwm", int'(pfm_mode), 0);
    end

    // R9: comparator moves during a pulse and early in off-interval
    en = 1'b0;
    step();
    on_len_pwm = 8'd5; off_len = 8'd6; on_len_pfm = 8'd12;
    en = 1'b1;
    step();
    above_ref = 1'b1;
    count_level(1'b1, hi);
    check("R9 on length unchanged", hi, 5);
    step(); step();
    above_ref = 1'b0;
    count_level(1'b0, lo);
    check("R9 off length unchanged", lo, 4);
    check("R9 still pwm", int'(pfm_mode), 0);

    // R4 R5 R6 R7: enter, hold, fire, return
    count_level(1'b1, hi);
    above_ref = 1'b1;
    count_level(1'b0, lo);
    check("R4 no pulse while above", lo, LIMIT);
    check("R4 pfm entered", int'(pfm_mode), 1);
    for (int i = 0; i < 20; i++) begin
      if (sw_drive) begin
        check("R5 held low", 1, 0);
      end
      step();
    end
    check("R5 held low after wait", int'(sw_drive), 0);
    above_ref = 1'b0;
    step();
    check("R6 fires next edge", int'(sw_drive), 1);
    check("R6 pfm during pulse", int'(pfm_mode), 1);
    count_level(1'b1, hi);
    check("R6 lengthened pulse", hi, 12);
    count_level(1'b0, lo);
    check("R3 off after pfm pulse", lo, 6);
    check("R7 back to pwm", int'(pfm_mode), 0);
    count_level(1'b1, hi);
    check("R7 pwm pulse length", hi, 5);

    // R8 R1: enable dropped mid-pulse clears pfm and timing
    wait_rise();
    step(); step();
    en = 1'b0;
    step();
    check("R8 pulse cut", int'(sw_drive), 0);
    check("R1 pfm cleared", int'(pfm_mode), 0);
    repeat (5) step();
    check("R1 stays low", int'(sw_drive), 0);
    en = 1'b1;
    step();
    check("R8 restart", int'(sw_drive), 1);
    count_level(1'b1, hi);
    check("R8 full length", hi, 5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule